// File: doc/BRIEF.md
# Combined Read-Modify-Write ALU Executor

This block carries out the combined instructions of an 8-bit accumulator CPU with NMOS-style decoding. Each of these instructions first alters a memory byte with a shift, a rotate, an increment or a decrement, and writes the altered byte back. It then uses that same altered byte as the operand of an accumulator operation. The memory work is finished inside the instruction. The accumulator and flag update is held back until the cycle in which the next opcode would be fetched.

The surrounding core decodes the address and runs the bus. It pulses `start` with the opcode, the accumulator, the carry and overflow flags, and the operand byte on `mem_rdata`. The block then requests one read and two writes, and it raises `res_valid` for the cycle in which the new accumulator and flags take effect. The immediate column needs no memory cycles. In that case the accumulator operation is applied straight to the operand, one cycle after the start.

Top module: `rmw_alu_exec`

## Requirements
- R1: While reset is held and after it is released: `busy`, `bus_rd`, `bus_wr` and `res_valid` are low, and `acc_out` and all four flag outputs are zero.
- R2: A start is taken only when the block is idle, opcode bits 1:0 are 11, and opcode bits 7:5 are 0, 1, 2, 3, 6 or 7. Any other start makes no bus request and no `res_valid`, and it leaves `acc_out` and the flags unchanged.
- R3: For a memory form (opcode bits 4:2 not 010), `bus_rd` is high in cycle 1 after the start cycle and `bus_wr` is high in cycles 2 and 3. `res_valid` pulses in cycle 4.
- R4: The first write carries the byte that was read. The second write carries the byte after the memory step.
- R5: The memory step is chosen by opcode bits 7:5. The codes are: 0 shift left (a 0 enters, bit 7 goes to carry); 1 rotate left through carry; 2 shift right (a 0 enters, bit 0 goes to carry); 3 rotate right through carry; 6 decrement by one; 7 increment by one. Increment and decrement leave the carry unchanged.
- R6: The carry that leaves the memory step is the carry input of the accumulator step.
- R7: Rows 0, 1 and 2 set the accumulator to accumulator OR, AND or XOR the altered byte. N is bit 7 of the result, Z is set when the result is zero, C is the memory-step carry, and V is unchanged.
- R8: Row 3 adds the altered byte plus the carry. Row 7 subtracts the altered byte with the carry acting as an inverted borrow. Both use binary arithmetic, C is the carry out, and V is the signed overflow.
- R9: Row 6 compares the accumulator with the altered byte. The accumulator stays unchanged. C is set when the accumulator is greater than or equal to the byte, Z is set when they are equal, N is bit 7 of the difference, and V is unchanged.
- R10: For the immediate form (opcode bits 4:2 = 010), there is no bus cycle. The row's accumulator step is applied to `mem_rdata` with the incoming carry, and `res_valid` pulses in cycle 1 after the start.
- R11: `res_valid` lasts one cycle. `acc_out` and the flags change only in a `res_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a combined instruction |
| opcode | input | 8 | Opcode of the instruction |
| mem_rdata | input | DW | Memory byte, or the immediate operand |
| acc_in | input | DW | Accumulator at start |
| carry_in | input | 1 | Carry flag at start |
| ovf_in | input | 1 | Overflow flag at start |
| busy | output | 1 | A memory sequence is in progress |
| bus_rd | output | 1 | Read request |
| bus_wr | output | 1 | Write request |
| bus_wdata | output | DW | Write data |
| acc_out | output | DW | Committed accumulator |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| res_valid | output | 1 | Deferred update applied this cycle |

## Verification
Every output is a register, so results fall in fixed cycles after the start cycle. For a memory form, the read request comes in cycle 1, the two writes in cycles 2 and 3, and the accumulator commit in cycle 4. For the immediate form the commit comes in cycle 1. The bench drives and samples on falling edges and counts those edges from the start before it compares each output. It samples once more in the following cycle to confirm that the pulse has ended and the committed values are held.

// File: rtl/rmw_exec_pkg.sv
package rmw_exec_pkg;
  typedef enum logic [2:0] {
    PAIR_ASL_OR  = 3'd0,
    PAIR_ROL_AND = 3'd1,
    PAIR_LSR_XOR = 3'd2,
    PAIR_ROR_ADD = 3'd3,
    PAIR_RSV4    = 3'd4,
    PAIR_RSV5    = 3'd5,
    PAIR_DEC_CMP = 3'd6,
    PAIR_INC_SUB = 3'd7
  } pair_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_READ, ST_WR_OLD, ST_WR_NEW
  } seq_e;

  localparam logic [1:0] GROUP_COMBINED = 2'b11;
  localparam logic [2:0] COL_IMMEDIATE  = 3'b010;

  function automatic logic pair_supported(input pair_e p);
    return !(p == PAIR_RSV4 || p == PAIR_RSV5);
  endfunction
endpackage

// File: rtl/rmw_mem_step.sv
module rmw_mem_step
  import rmw_exec_pkg::*;
#(
  parameter int DW = 8
) (
  input  pair_e          pair,
  input  logic [DW-1:0]  din,
  input  logic           cin,
  output logic [DW-1:0]  dout,
  output logic           cout
);
  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    dout = din;
    cout = cin;
    case (pair)
      PAIR_ASL_OR:  {cout, dout} = {din, 1'b0};
      PAIR_ROL_AND: {cout, dout} = {din, cin};
      PAIR_LSR_XOR: {dout, cout} = {1'b0, din};
      PAIR_ROR_ADD: {dout, cout} = {cin, din};
      PAIR_DEC_CMP: dout = din - ONE;
      PAIR_INC_SUB: dout = din + ONE;
      default: ;
    endcase
  end
endmodule

// File: rtl/rmw_acc_step.sv
module rmw_acc_step
  import rmw_exec_pkg::*;
#(
  parameter int DW = 8
) (
  input  pair_e          pair,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  m,
  input  logic           cin,
  input  logic           vin,
  output logic [DW-1:0]  res,
  output logic           n,
  output logic           v,
  output logic           z,
  output logic           c
);
  localparam int MSB = DW - 1;
  logic          inv;
  logic [DW-1:0] m_eff;
  logic          c_add;
  logic [DW:0]   sum;

  assign inv   = (pair == PAIR_DEC_CMP) || (pair == PAIR_INC_SUB);
  assign m_eff = inv ? ~m : m;
  assign c_add = (pair == PAIR_DEC_CMP) ? 1'b1 : cin;
  assign sum   = {1'b0, a} + {1'b0, m_eff} + {{DW{1'b0}}, c_add};

  always_comb begin
    res = a;
    v   = vin;
    c   = cin;
    case (pair)
      PAIR_ASL_OR:  res = a | m;
      PAIR_ROL_AND: res = a & m;
      PAIR_LSR_XOR: res = a ^ m;
      PAIR_ROR_ADD, PAIR_INC_SUB: begin
        res = sum[DW-1:0];
        c   = sum[DW];
        v   = (a[MSB] == m_eff[MSB]) && (sum[MSB] != a[MSB]);
      end
      PAIR_DEC_CMP: c = sum[DW];
      default: ;
    endcase
    if (pair == PAIR_DEC_CMP) begin
      n = sum[MSB];
      z = (sum[DW-1:0] == '0);
    end else begin
      n = res[MSB];
      z = (res == '0);
    end
  end
endmodule

// File: rtl/rmw_alu_exec.sv
module rmw_alu_exec
  import rmw_exec_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] acc_in,
  input  logic          carry_in,
  input  logic          ovf_in,
  output logic          busy,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] acc_out,
  output logic          flag_n,
  output logic          flag_v,
  output logic          flag_z,
  output logic          flag_c,
  output logic          res_valid
);
  seq_e          st;
  pair_e         pair_q;
  logic [DW-1:0] acc_q, data_q;
  logic          c_q, v_q;

  pair_e         pair_in;
  logic          accept, is_imm, idle;
  logic [DW-1:0] mod_d;
  logic          mod_c;

  pair_e         alu_pair;
  logic [DW-1:0] alu_a, alu_m, alu_res;
  logic          alu_cin, alu_vin, alu_n, alu_v, alu_z, alu_c;

  assign pair_in = pair_e'(opcode[7:5]);
  assign idle    = (st == ST_IDLE);
  assign is_imm  = (opcode[4:2] == COL_IMMEDIATE);
  assign accept  = start && idle && (opcode[1:0] == GROUP_COMBINED) &&
                   pair_supported(pair_in);
  assign busy    = !idle;

  rmw_mem_step #(.DW(DW)) u_mem (
    .pair(pair_q), .din(data_q), .cin(c_q), .dout(mod_d), .cout(mod_c)
  );

  // Idle: immediate operand straight from ports; otherwise the captured state.
  assign alu_pair = idle ? pair_in   : pair_q;
  assign alu_a    = idle ? acc_in    : acc_q;
  assign alu_m    = idle ? mem_rdata : mod_d;
  assign alu_cin  = idle ? carry_in  : mod_c;
  assign alu_vin  = idle ? ovf_in    : v_q;

  rmw_acc_step #(.DW(DW)) u_alu (
    .pair(alu_pair), .a(alu_a), .m(alu_m), .cin(alu_cin), .vin(alu_vin),
    .res(alu_res), .n(alu_n), .v(alu_v), .z(alu_z), .c(alu_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pair_q    <= PAIR_ASL_OR;
      acc_q     <= '0;
      data_q    <= '0;
      c_q       <= 1'b0;
      v_q       <= 1'b0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_wdata <= '0;
      acc_out   <= '0;
      flag_n    <= 1'b0;
      flag_v    <= 1'b0;
      flag_z    <= 1'b0;
      flag_c    <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      res_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            pair_q <= pair_in;
            acc_q  <= acc_in;
            c_q    <= carry_in;
            v_q    <= ovf_in;
            if (is_imm) begin
              acc_out   <= alu_res;
              flag_n    <= alu_n;
              flag_v    <= alu_v;
              flag_z    <= alu_z;
              flag_c    <= alu_c;
              res_valid <= 1'b1;
            end else begin
              bus_rd <= 1'b1;
              st     <= ST_READ;
            end
          end
        end
        ST_READ: begin
          data_q    <= mem_rdata;
          bus_wdata <= mem_rdata;
          bus_wr    <= 1'b1;
          st        <= ST_WR_OLD;
        end
        ST_WR_OLD: begin
          bus_wdata <= mod_d;
          bus_wr    <= 1'b1;
          st        <= ST_WR_NEW;
        end
        ST_WR_NEW: begin
          acc_out   <= alu_res;
          flag_n    <= alu_n;
          flag_v    <= alu_v;
          flag_z    <= alu_z;
          flag_c    <= alu_c;
          res_valid <= 1'b1;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rmw_alu_exec_chk.sv
module rmw_alu_exec_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] acc_out,
  input logic          res_valid
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!bus_rd && !bus_wr)); // R2
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr)); // R3
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> (bus_wr && !bus_rd)); // R3
  AST_SECOND_WR: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> ##1 bus_wr); // R3
  AST_COMMIT_SLOT: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> ##2 res_valid); // R3
  AST_WR_ORIG: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> (bus_wdata == $past(mem_rdata))); // R4
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R11
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(acc_out) |-> res_valid); // R11
endmodule

bind rmw_alu_exec rmw_alu_exec_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .mem_rdata(mem_rdata), .acc_out(acc_out),
  .res_valid(res_valid)
);

// File: tb/tb_rmw_alu_exec.sv
module tb_rmw_alu_exec;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [7:0] mem_rdata = 8'h00;
  logic [7:0] acc_in = 8'h00;
  logic       carry_in = 1'b0;
  logic       ovf_in = 1'b0;
  logic       busy, bus_rd, bus_wr, res_valid;
  logic [7:0] bus_wdata, acc_out;
  logic       flag_n, flag_v, flag_z, flag_c;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rmw_alu_exec #(.DW(8)) dut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode),
    .mem_rdata(mem_rdata), .acc_in(acc_in), .carry_in(carry_in),
    .ovf_in(ovf_in), .busy(busy), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .acc_out(acc_out), .flag_n(flag_n),
    .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c), .res_valid(res_valid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Expected {altered byte, acc, N, V, Z, C}, derived from the requirement text
  function automatic logic [19:0] model(input logic [7:0] op, d, a, input logic c, v);
    logic [7:0] m, r;
    logic cm, nn, vv, zz, cc;
    logic [8:0] s;
    m = d; cm = c;
    if (op[4:2] != 3'b010) begin
      case (op[7:5])
        3'd0: begin cm = d[7]; m = {d[6:0], 1'b0}; end
        3'd1: begin cm = d[7]; m = {d[6:0], c};    end
        3'd2: begin cm = d[0]; m = {1'b0, d[7:1]}; end
        3'd3: begin cm = d[0]; m = {c, d[7:1]};    end
        3'd6: m = d - 8'd1;
        3'd7: m = d + 8'd1;
        default: ;
      endcase
    end
    r = a; vv = v; cc = cm; nn = 1'b0; zz = 1'b0;
    case (op[7:5])
      3'd0: r = a | m;
      3'd1: r = a & m;
      3'd2: r = a ^ m;
      3'd3: begin
        s = {1'b0, a} + {1'b0, m} + {8'd0, cm};
        r = s[7:0]; cc = s[8];
        vv = (a[7] == m[7]) && (r[7] != a[7]);
      end
      3'd7: begin
        s = {1'b0, a} + {1'b0, ~m} + {8'd0, cm};
        r = s[7:0]; cc = s[8];
        vv = (a[7] != m[7]) && (r[7] != a[7]);
      end
      default: ;
    endcase
    if (op[7:5] == 3'd6) begin
      s = {1'b0, a} - {1'b0, m};
      nn = s[7]; zz = (a == m); cc = (a >= m);
    end else begin
      nn = r[7]; zz = (r == 8'd0);
    end
    return {m, r, nn, vv, zz, cc};
  endfunction

  task automatic check_result(input logic [19:0] e, input string tag);
    check(res_valid == 1'b1, {tag, " res_valid"}, int'(res_valid), 1);
    check(acc_out == e[11:4], {tag, " acc"}, int'(acc_out), int'(e[11:4]));
    check({flag_n, flag_v, flag_z, flag_c} == e[3:0], {tag, " NVZC"},
          int'({flag_n, flag_v, flag_z, flag_c}), int'(e[3:0]));
  endtask

  // Memory form; intrude drives a second start while the first runs
  task automatic run_mem(input logic [7:0] op, d, a, input logic c, v,
                         input string tag, input bit intrude);
    logic [19:0] e;
    logic [7:0] acc_held;
    e = model(op, d, a, c, v);
    @(negedge clk);
    start = 1'b1; opcode = op; mem_rdata = d; acc_in = a; carry_in = c; ovf_in = v;
    @(negedge clk);
    if (intrude) begin
      opcode = 8'hE7; acc_in = 8'hAA; carry_in = ~c;
    end else start = 1'b0;
    check(bus_rd && !bus_wr && busy, "R3 read in cycle 1", int'({bus_rd, bus_wr}), 2);
    @(negedge clk);
    check(bus_wr && !bus_rd, "R3 first write in cycle 2", int'({bus_rd, bus_wr}), 1);
    check(bus_wdata == d, "R4 first write is original", int'(bus_wdata), int'(d));
    @(negedge clk);
    start = 1'b0;
    check(bus_wr && !res_valid, "R3 second write in cycle 3", int'(bus_wr), 1);
    check(bus_wdata == e[19:12], {"R4 R5 altered byte ", tag}, int'(bus_wdata), int'(e[19:12]));
    @(negedge clk);
    check(!bus_wr && !bus_rd, "R3 no bus in commit cycle", int'({bus_rd, bus_wr}), 0);
    check_result(e, tag);
    acc_held = acc_out;
    @(negedge clk);
    check(!res_valid && acc_out == acc_held && !busy, "R11 pulse ends, acc held",
          int'({res_valid, acc_out}), int'({1'b0, acc_held}));
  endtask

  task automatic run_imm(input logic [7:0] op, d, a, input logic c, v, input string tag);
    logic [19:0] e;
    e = model(op, d, a, c, v);
    @(negedge clk);
    start = 1'b1; opcode = op; mem_rdata = d; acc_in = a; carry_in = c; ovf_in = v;
    @(negedge clk);
    start = 1'b0;
    check(!bus_rd && !bus_wr && !busy, "R10 no bus cycles", int'({busy, bus_rd, bus_wr}), 0);
    check_result(e, tag);
    @(negedge clk);
    check(!res_valid, "R11 immediate pulse ends", int'(res_valid), 0);
  endtask

  task automatic run_ignored(input logic [7:0] op, input string tag);
    logic [11:0] held;
    held = {acc_out, flag_n, flag_v, flag_z, flag_c};
    @(negedge clk);
    start = 1'b1; opcode = op; mem_rdata = 8'h5A; acc_in = 8'h33; carry_in = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(!busy && !bus_rd && !bus_wr && !res_valid, {tag, " no activity"},
            int'({busy, bus_rd, bus_wr, res_valid}), 0);
      @(negedge clk);
    end
    check({acc_out, flag_n, flag_v, flag_z, flag_c} == held, {tag, " state held"},
          int'({acc_out, flag_n, flag_v, flag_z, flag_c}), int'(held));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !bus_rd && !bus_wr && !res_valid, "R1 idle during reset",
          int'({busy, bus_rd, bus_wr, res_valid}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(acc_out == 8'h00 && {flag_n, flag_v, flag_z, flag_c} == 4'h0,
          "R1 outputs zero after reset", int'({acc_out, flag_n, flag_v, flag_z, flag_c}), 0);

    run_mem(8'h07, 8'h81, 8'h10, 1'b0, 1'b0, "R5 R6 R7 shl/or", 1'b0);
    run_mem(8'h27, 8'h80, 8'hFF, 1'b1, 1'b1, "R5 R6 R7 rol/and", 1'b0);
    run_mem(8'h4F, 8'h01, 8'h00, 1'b0, 1'b0, "R5 R6 R7 shr/xor zero", 1'b0);
    run_mem(8'h67, 8'h01, 8'h7F, 1'b0, 1'b0, "R6 R8 ror/add carry fed, overflow", 1'b0);
    run_mem(8'h77, 8'h00, 8'h05, 1'b1, 1'b0, "R5 R8 ror/add carry in rotated", 1'b0);
    run_mem(8'hC7, 8'h00, 8'h10, 1'b1, 1'b1, "R9 dec/cmp less", 1'b0);
    run_mem(8'hD7, 8'h11, 8'h10, 1'b0, 1'b0, "R9 dec/cmp equal", 1'b0);
    run_mem(8'hE7, 8'hFF, 8'h05, 1'b1, 1'b0, "R8 inc/sub wrap", 1'b0);
    run_mem(8'hFF, 8'h7F, 8'h00, 1'b1, 1'b0, "R8 inc/sub borrow overflow", 1'b0);
    run_mem(8'h07, 8'h40, 8'h01, 1'b1, 1'b0, "R2 start while busy ignored", 1'b1);

    run_imm(8'h0B, 8'hF0, 8'h0F, 1'b1, 1'b0, "R10 immediate or");
    run_imm(8'h6B, 8'h01, 8'hFF, 1'b0, 1'b0, "R10 immediate add");
    run_imm(8'hEB, 8'h01, 8'h00, 1'b1, 1'b0, "R10 immediate sub");

    run_ignored(8'h05, "R2 group 01");
    run_ignored(8'h87, "R2 row 80");
    run_ignored(8'hA7, "R2 row A0");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule